// File: doc/BRIEF.md
# Decimal Adder-Subtractor with Gated Nines Complementer

This block adds or subtracts two packed BCD operands of a parameterised number of digits, purely combinationally. Every digit of the second operand first goes through a gated nines-complement stage. That stage can pass the digit through, complement it, or force it to zero. The result then enters a ripple chain of decimal-corrected digit adders. The add/subtract select drives the complement control directly. In subtract mode it also forces the carry into the lowest digit, so the chain produces A + (10^N − 1 − B) + 1. That value is the ten's-complement difference.

A separate disable input overrides the select at the operand stage, so the digit goes through uncomplemented. A zero-force input clears the second operand and takes precedence over both. Digits from 10 to 15 on either operand only raise a flag. The sum and carry for such inputs are unspecified.

Top module: `bcd_addsub`

## Requirements
- R1: Operand digit k sits in bits [4k+3:4k] with 8-4-2-1 weights, and digit 0 is the least significant. The result uses the same layout.
- R2: While zero_i is high, the second operand contributes 0 to the sum. This holds for every value of sub_i and comp_dis_i.
- R3: While sub_i is low and zero_i is low, each second-operand digit enters the adder unchanged.
- R4: While sub_i is high and comp_dis_i and zero_i are low, each valid second-operand digit d enters the adder as 9 − d.
- R5: While comp_dis_i is high and zero_i is low, each second-operand digit enters unchanged, even when sub_i is high.
- R6: The carry into digit 0 is cin_i OR sub_i.
- R7: Each digit adder forms the binary sum of its two digits and its incoming carry. A sum above 9 is corrected by adding 6, keeping the low four bits, and sets that digit's carry-out.
- R8: For valid inputs, cout_o·10^N + value(sum_o) equals value(a_i) + value(operand entering the adder) + carry into digit 0.
- R9: In plain subtraction (sub_i=1, comp_dis_i=0, zero_i=0), A ≥ B gives cout_o=1 and sum_o=A−B. A < B gives cout_o=0 and sum_o=10^N−(B−A).
- R10: bad_digit_o is high exactly when some digit of a_i or b_i holds a value from 10 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4·NDIG | First packed BCD operand |
| b_i | input | 4·NDIG | Second packed BCD operand, passes through the complementer |
| sub_i | input | 1 | Add (0) or subtract (1) select; complement control |
| comp_dis_i | input | 1 | Suppresses the complement |
| zero_i | input | 1 | Forces the second operand to zero, highest priority |
| cin_i | input | 1 | Carry into the lowest digit |
| sum_o | output | 4·NDIG | Packed BCD result |
| cout_o | output | 1 | Decimal carry out of the highest digit |
| bad_digit_o | output | 1 | Some input digit is 10 to 15 |

## Verification
The bench builds two copies of the block. One has NDIG=1. It is driven exhaustively over every pair of valid digits under every combination of the four controls, and over all 256 nibble pairs for the invalid flag. The other has NDIG=4 and receives random operands together with chosen edge operands such as 9999+1 and 0−1. These reach carries that ripple through all four digit stages, and ten's-complement wrap across the full width. A decimal integer model in the bench supplies the expected sum and carry.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  localparam bcd_digit_t MAX_DIGIT = 4'd9;
endpackage

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
  import bcd_pkg::*;
(
  input  bcd_digit_t din_i,
  input  logic       comp_i,
  input  logic       dis_i,
  input  logic       zero_i,
  output bcd_digit_t dout_o
);
  bcd_digit_t nines;
  logic       do_comp;

  always_comb begin
    nines[0] = ~din_i[0];
    nines[1] = din_i[1];
    nines[2] = din_i[1] ^ din_i[2];
    nines[3] = ~(din_i[1] | din_i[2] | din_i[3]);
    do_comp  = comp_i & ~dis_i;
    if (zero_i)       dout_o = '0;
    else if (do_comp) dout_o = nines;
    else              dout_o = din_i;
  end

  always_comb begin
    if (zero_i) a_r2_zero_force : assert (dout_o == '0);
    if (!zero_i && comp_i && !dis_i && din_i <= MAX_DIGIT)
      a_r4_nines_total : assert (({1'b0, din_i} + {1'b0, dout_o}) == 5'd9);
    if (!zero_i && (!comp_i || dis_i))
      a_r5_pass_through : assert (dout_o == din_i); // R3 and R5
  end
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_pkg::*;
(
  input  bcd_digit_t x_i,
  input  bcd_digit_t y_i,
  input  logic       c_i,
  output bcd_digit_t d_o,
  output logic       c_o
);
  logic [DIGIT_W:0] raw;
  logic             over;

  always_comb begin
    raw  = {1'b0, x_i} + {1'b0, y_i} + {{DIGIT_W{1'b0}}, c_i};
    over = raw > {1'b0, MAX_DIGIT};
    d_o  = over ? raw[DIGIT_W-1:0] + 4'd6 : raw[DIGIT_W-1:0];
    c_o  = over;
  end

  always_comb begin
    if (x_i <= MAX_DIGIT && y_i <= MAX_DIGIT) begin
      a_r7_digit_range : assert (d_o <= MAX_DIGIT);
      a_r7_digit_value : assert (((c_o ? 5'd10 : 5'd0) + {1'b0, d_o}) ==
                                 ({1'b0, x_i} + {1'b0, y_i} + {4'b0, c_i}));
    end
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic [4*NDIG-1:0] a_i,
  input  logic [4*NDIG-1:0] b_i,
  input  logic              sub_i,
  input  logic              comp_dis_i,
  input  logic              zero_i,
  input  logic              cin_i,
  output logic [4*NDIG-1:0] sum_o,
  output logic              cout_o,
  output logic              bad_digit_o
);
  localparam int W = DIGIT_W * NDIG;

  logic [NDIG:0]   carry;
  logic [NDIG-1:0] dig_bad;
  logic [W-1:0]    b_eff;

  assign carry[0] = cin_i | sub_i;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    bcd_digit_t a_d, b_d;
    assign a_d = a_i[DIGIT_W*k +: DIGIT_W];
    assign b_d = b_i[DIGIT_W*k +: DIGIT_W];
    assign dig_bad[k] = (a_d > MAX_DIGIT) | (b_d > MAX_DIGIT);

    bcd_nines_comp u_comp (
      .din_i  (b_d),
      .comp_i (sub_i),
      .dis_i  (comp_dis_i),
      .zero_i (zero_i),
      .dout_o (b_eff[DIGIT_W*k +: DIGIT_W])
    );

    bcd_digit_add u_add (
      .x_i (a_d),
      .y_i (b_eff[DIGIT_W*k +: DIGIT_W]),
      .c_i (carry[k]),
      .d_o (sum_o[DIGIT_W*k +: DIGIT_W]),
      .c_o (carry[k+1])
    );
  end

  assign cout_o      = carry[NDIG];
  assign bad_digit_o = |dig_bad;

  always_comb begin
    if (zero_i && !bad_digit_o)
      a_r2_sum_is_a : assert ((sum_o == a_i && !cout_o) || carry[0]);
  end
endmodule

// File: tb/bcd_addsub_tb.sv
module bcd_addsub_tb_top;
  localparam int N4 = 4;
  localparam int N1 = 1;

  logic clk;
  logic rst_n;
  int   n_checks;
  int   n_errs;
  int   cyc;
  bit   done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [4*N4-1:0] a4, b4, s4;
  logic            sub4, dis4, zero4, cin4, co4, bad4;
  logic [3:0]      a1, b1, s1;
  logic            sub1, dis1, zero1, cin1, co1, bad1;

  bcd_addsub #(.NDIG(N4)) dut_i (
    .a_i(a4), .b_i(b4), .sub_i(sub4), .comp_dis_i(dis4), .zero_i(zero4),
    .cin_i(cin4), .sum_o(s4), .cout_o(co4), .bad_digit_o(bad4));

  bcd_addsub #(.NDIG(N1)) dut1_i (
    .a_i(a1), .b_i(b1), .sub_i(sub1), .comp_dis_i(dis1), .zero_i(zero1),
    .cin_i(cin1), .sum_o(s1), .cout_o(co1), .bad_digit_o(bad1));

  function automatic logic [15:0] to_bcd(int v);
    logic [15:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(logic [15:0] p);
    int r = 0;
    for (int k = 3; k >= 0; k--) r = r * 10 + int'(p[4*k +: 4]);
    return r;
  endfunction

  task automatic report(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(int a, int b, bit sb, bit ds, bit zr, bit ci,
                               int lim);
    int bv;
    if (zr) bv = 0;
    else if (sb && !ds) bv = lim - 1 - b;
    else bv = b;
    return a + bv + int'(sb | ci);
  endfunction

  task automatic run4(int a, int b, bit sb, bit ds, bit zr, bit ci, string req);
    int tot;
    @(posedge clk); #1;
    a4 = to_bcd(a); b4 = to_bcd(b); sub4 = sb; dis4 = ds; zero4 = zr; cin4 = ci;
    tot = model(a, b, sb, ds, zr, ci, 10000);
    @(negedge clk);
    report(from_bcd(s4) == tot % 10000, req, from_bcd(s4), tot % 10000);
    report(int'(co4) == tot / 10000, {req, " carry"}, int'(co4), tot / 10000);
  endtask

  task automatic run1(int a, int b, bit sb, bit ds, bit zr, bit ci, string req);
    int tot;
    @(posedge clk); #1;
    a1 = 4'(a); b1 = 4'(b); sub1 = sb; dis1 = ds; zero1 = zr; cin1 = ci;
    tot = model(a, b, sb, ds, zr, ci, 10);
    @(negedge clk);
    report(int'(s1) == tot % 10 && int'(co1) == tot / 10, req,
           int'(co1) * 10 + int'(s1), tot);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_errs = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0;
    a4 = '0; b4 = '0; sub4 = 0; dis4 = 0; zero4 = 0; cin4 = 0;
    a1 = '0; b1 = '0; sub1 = 0; dis1 = 0; zero1 = 0; cin1 = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report(s4 == '0 && !co4 && !bad4, "R8 idle", int'(s4), 0);

    // Exhaustive one-digit sweep: R2 R3 R4 R5 R6 R7 R8
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int m = 0; m < 16; m++)
          run1(a, b, m[0], m[1], m[2], m[3], "R7 digit");

    // R10 flag over every nibble pair (only flag is defined)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        @(posedge clk); #1;
        a1 = 4'(a); b1 = 4'(b); sub1 = 0; dis1 = 0; zero1 = 0; cin1 = 0;
        @(negedge clk);
        report(bad1 == (a > 9 || b > 9), "R10 flag", int'(bad1), int'(a > 9 || b > 9));
      end

    // Four-digit edges
    run4(9999, 1, 0, 0, 0, 0, "R8 full ripple");
    run4(9999, 9999, 0, 0, 0, 1, "R8 max add");
    run4(0, 1, 1, 0, 0, 0, "R9 negative wrap");
    run4(1234, 1234, 1, 0, 0, 0, "R9 equal");
    run4(5000, 1, 1, 0, 0, 0, "R9 borrow chain");
    run4(4321, 8765, 1, 1, 0, 0, "R5 disable");
    run4(4321, 8765, 1, 0, 1, 0, "R2 zero sub");
    run4(4321, 8765, 0, 0, 1, 1, "R2 zero add");
    run4(7, 0, 0, 0, 0, 1, "R6 cin");
    run4(1090, 910, 0, 0, 0, 0, "R1 layout");

    // R9 explicit sign rule and random R3/R4/R8
    for (int i = 0; i < 1500; i++) begin
      int a = $urandom_range(0, 9999);
      int b = $urandom_range(0, 9999);
      int sel = $urandom_range(0, 15);
      run4(a, b, sel[0], sel[1], sel[2], sel[3], "R8 random");
      if (!sel[1] && !sel[2] && sel[0]) begin
        report(co4 == (a >= b), "R9 sign", int'(co4), int'(a >= b));
        report(from_bcd(s4) == (a >= b ? a - b : 10000 - (b - a)), "R9 diff",
               from_bcd(s4), (a >= b ? a - b : 10000 - (b - a)));
      end
    end

    // R10 on the wide instance: one bad digit placed at each position
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      a4 = to_bcd(1111); b4 = to_bcd(2222);
      if (k[0]) b4[4*k +: 4] = 4'hC; else a4[4*k +: 4] = 4'hA;
      @(negedge clk);
      report(bad4 == 1'b1, "R10 wide", int'(bad4), 1);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule